// File: doc/BRIEF.md
# Fetch Sequencer with One Branch Delay Slot

This block is the program-counter and fetch-control front end of a five-stage in-order pipeline. Its stages are fetch, decode with register read, execute with address calculation, data-memory access and write-back. Each cycle it drives a word address to a combinational instruction memory. It captures the returned word, together with the address it came from, into a fetch output register that the decode stage reads.

Decode resolves branches and jumps by the end of its stage. It reports them back as a branch-present strobe, a taken flag and a target. The architecture has exactly one delay slot. The word fetched while decode holds a branch always goes down the pipe, whether or not the branch is taken. A taken branch only steers the fetch that comes after that slot, so the slot word is never flushed.

A stall input freezes the program counter and the fetch output register. A redirect that arrives during a stall is remembered until the stall clears. An inject input replaces the captured word with the all-zero no-op, which is a logical left shift of register zero into itself by zero. A combinational flag warns when decode reports a branch for a word that was itself fetched into a delay slot.

Top module: `fetch_sequencer`

## Requirements
- R1: While `rstN` is low, `imemAddr` reads 0x0000_0000, and `fetchValid`, `fetchSlot`, `fetchPc` and `fetchInstr` all read zero. No redirect is remembered across reset.
- R2: On each rising edge with `stallIn` low and no redirect, `imemAddr` steps by 4. On the same edge `fetchInstr` takes the memory word at the old address, `fetchPc` takes that old address, and `fetchValid` goes to 1.
- R3: On a rising edge with `stallIn` high, `imemAddr`, `fetchValid`, `fetchInstr`, `fetchPc` and `fetchSlot` keep their values.
- R4: When decode reports a taken branch (`decBranch`=1, `decTaken`=1) on an unstalled edge, the word at the current `imemAddr` is still captured as the delay slot. `imemAddr` then becomes `decTarget`.
- R5: A branch reported as not taken (`decTaken`=0) leaves the address sequence unchanged, stepping by 4, and its target is ignored.
- R6: `fetchSlot` is 1 exactly for a word captured on an edge where decode reported a branch (taken or not), or where a branch reported during an earlier stall is still remembered. Otherwise `fetchSlot` is 0.
- R7: A taken branch reported while `stallIn` is high is kept. On the first unstalled edge it redirects `imemAddr` to its target and tags the captured word as a slot, even if decode has dropped its report by then.
- R8: With `injectNop` high on an unstalled edge, `fetchInstr` captures 0x0000_0000 in place of the memory word. `fetchPc` still takes the address and `imemAddr` still advances. With `stallIn` high, `injectNop` has no effect.
- R9: `branchInSlot` is 1 whenever `decBranch` is high, `fetchValid` is 1 and `fetchSlot` is 1; otherwise it is 0.
- R10: A branch report while `fetchValid` is 0 is ignored: there is no redirect and no slot tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| stallIn | input | 1 | Freeze program counter and fetch output |
| injectNop | input | 1 | Capture the all-zero no-op instead of the memory word |
| decBranch | input | 1 | Decode holds a resolved branch or jump |
| decTaken | input | 1 | The reported branch is taken |
| decTarget | input | ADDR_W | Target address of the reported branch |
| imemAddr | output | ADDR_W | Word address to instruction memory |
| imemData | input | DATA_W | Word returned by instruction memory for imemAddr |
| fetchValid | output | 1 | Fetch output holds an instruction |
| fetchInstr | output | DATA_W | Instruction handed to decode |
| fetchPc | output | ADDR_W | Address of fetchInstr |
| fetchSlot | output | 1 | fetchInstr sits in a branch delay slot |
| branchInSlot | output | 1 | Decode reports a branch on a delay-slot word |

## Verification
The delay slot itself is the first target: a design that flushed the slot, or redirected one fetch too early, would deliver the target word where the slot address is expected. A not-taken branch with a distinct target catches a design that jumps regardless of the taken flag. The stall window is checked with decode dropping its report halfway through the stall, which exposes a design that forgets the redirect. Inject is applied both unstalled and stalled, to catch a zeroed word that overwrites held state. A branch report made before any word is valid, and a branch reported for a slot word, cover the two status and guard cases.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  // Strobes passed from the fetch control to the fetch datapath each cycle.
  typedef struct packed {
    logic advance;   // take a new word, step or redirect the pc
    logic redirect;  // load the redirect address instead of pc + step
    logic markSlot;  // the word captured now is a delay-slot word
    logic zeroWord;  // capture the all-zero no-op instead of memory data
  } fseq_strobe_t;

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stallIn,
  input  logic              injectNop,
  input  logic              decBranch,
  input  logic              decTaken,
  input  logic [ADDR_W-1:0] decTarget,
  input  logic              fetchValid,
  input  logic              fetchSlot,
  output fseq_strobe_t      strobes,
  output logic [ADDR_W-1:0] redirectPc,
  output logic              branchInSlot
);

  logic              liveBranch;
  logic              liveTaken;
  logic              pendTaken;
  logic              pendSlot;
  logic [ADDR_W-1:0] pendTarget;

  // A report only counts when decode really holds a word.
  assign liveBranch = decBranch & fetchValid;
  assign liveTaken  = liveBranch & decTaken;

  always_comb begin
    strobes          = '0;
    strobes.advance  = ~stallIn;
    strobes.redirect = ~stallIn & (liveTaken | pendTaken);
    strobes.markSlot = liveBranch | pendSlot;
    strobes.zeroWord = injectNop;
  end

  assign redirectPc   = liveTaken ? decTarget : pendTarget;
  assign branchInSlot = liveBranch & fetchSlot;

  // Remember a redirect that shows up while the front end is frozen.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendTaken  <= 1'b0;
      pendSlot   <= 1'b0;
      pendTarget <= '0;
    end else if (stallIn) begin
      if (liveBranch) pendSlot <= 1'b1;
      if (liveTaken) begin
        pendTaken  <= 1'b1;
        pendTarget <= decTarget;
      end
    end else begin
      pendTaken <= 1'b0;
      pendSlot  <= 1'b0;
    end
  end

  // R7: a held redirect never outlives an unstalled edge
  a_r7_pending_cleared : assert property (@(posedge clk) disable iff (!rstN)
    !stallIn |=> !pendTaken);

  // R7: a taken report during a stall is still held on the next cycle
  a_r7_pending_kept : assert property (@(posedge clk) disable iff (!rstN)
    (stallIn && liveTaken) |=> pendTaken);

  // R4: every redirect also tags its captured word as a slot
  a_r4_redirect_tags_slot : assert property (@(posedge clk) disable iff (!rstN)
    strobes.redirect |-> strobes.markSlot);

  // R10: nothing redirects without a valid word in decode or a held redirect
  a_r10_no_redirect_invalid : assert property (@(posedge clk) disable iff (!rstN)
    (!fetchValid && !pendTaken) |-> !strobes.redirect);

endmodule

// File: rtl/fseq_dpath.sv
module fseq_dpath
  import fseq_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter int                PC_STEP  = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  fseq_strobe_t      strobes,
  input  logic [ADDR_W-1:0] redirectPc,
  input  logic [DATA_W-1:0] imemData,
  output logic [ADDR_W-1:0] pcOut,
  output logic              outValid,
  output logic [DATA_W-1:0] outWord,
  output logic [ADDR_W-1:0] outPc,
  output logic              outSlot
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(PC_STEP);
  localparam logic [DATA_W-1:0] NOP_W  = '0;

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] pcNext;

  assign pcNext = strobes.redirect ? redirectPc : pcReg + STEP_V;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg    <= RESET_PC;
      outValid <= 1'b0;
      outWord  <= '0;
      outPc    <= '0;
      outSlot  <= 1'b0;
    end else if (strobes.advance) begin
      pcReg    <= pcNext;
      outValid <= 1'b1;
      outWord  <= strobes.zeroWord ? NOP_W : imemData;
      outPc    <= pcReg;
      outSlot  <= strobes.markSlot;
    end
  end

  assign pcOut = pcReg;

  // R3: a frozen cycle leaves pc and fetch output untouched
  a_r3_stall_holds : assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> ($stable(pcReg) && $stable(outWord) && $stable(outPc)));

  // R2: a plain advance steps the pc
  a_r2_step : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.redirect) |=> pcReg == $past(pcReg) + STEP_V);

  // R2: the captured address is the one presented before the edge
  a_r2_pc_follows : assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> (outValid && outPc == $past(pcReg)));

  // R8: an injected word is the all-zero no-op
  a_r8_nop_zero : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && strobes.zeroWord) |=> outWord == NOP_W);

endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
  import fseq_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter int                PC_STEP  = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stallIn,
  input  logic              injectNop,
  input  logic              decBranch,
  input  logic              decTaken,
  input  logic [ADDR_W-1:0] decTarget,
  output logic [ADDR_W-1:0] imemAddr,
  input  logic [DATA_W-1:0] imemData,
  output logic              fetchValid,
  output logic [DATA_W-1:0] fetchInstr,
  output logic [ADDR_W-1:0] fetchPc,
  output logic              fetchSlot,
  output logic              branchInSlot
);

  fseq_strobe_t      strobes;
  logic [ADDR_W-1:0] redirectPc;

  fseq_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .stallIn      (stallIn),
    .injectNop    (injectNop),
    .decBranch    (decBranch),
    .decTaken     (decTaken),
    .decTarget    (decTarget),
    .fetchValid   (fetchValid),
    .fetchSlot    (fetchSlot),
    .strobes      (strobes),
    .redirectPc   (redirectPc),
    .branchInSlot (branchInSlot)
  );

  fseq_dpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PC_STEP  (PC_STEP),
    .RESET_PC (RESET_PC)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .redirectPc (redirectPc),
    .imemData   (imemData),
    .pcOut      (imemAddr),
    .outValid   (fetchValid),
    .outWord    (fetchInstr),
    .outPc      (fetchPc),
    .outSlot    (fetchSlot)
  );

  // R9: the slot-branch warning never fires on a non-slot word
  a_r9_warn_on_slot : assert property (@(posedge clk) disable iff (!rstN)
    branchInSlot |-> (fetchSlot && fetchValid));

endmodule

// File: tb/test_fetch_sequencer.sv
module test_fetch_sequencer;

  typedef struct packed {
    logic        stall;
    logic        inj;
    logic        bv;
    logic        bt;
    logic [31:0] tgt;
    logic        bis;
    logic [31:0] expAddr;
    logic [31:0] expPc;
    logic        expSlot;
    logic        expZero;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,1'b1,32'h100,1'b0,32'h004,32'h000,1'b0,1'b0}, // R10 report before valid
    '{1'b0,1'b0,1'b0,1'b0,32'h000,1'b0,32'h008,32'h004,1'b0,1'b0}, // R2
    '{1'b0,1'b0,1'b1,1'b1,32'h040,1'b0,32'h040,32'h008,1'b1,1'b0}, // R4 taken, slot at 8
    '{1'b0,1'b0,1'b0,1'b0,32'h000,1'b0,32'h044,32'h040,1'b0,1'b0}, // R4 target word
    '{1'b0,1'b0,1'b1,1'b0,32'h800,1'b0,32'h048,32'h044,1'b1,1'b0}, // R5 not taken
    '{1'b0,1'b0,1'b0,1'b0,32'h000,1'b0,32'h04C,32'h048,1'b0,1'b0}, // R6
    '{1'b1,1'b0,1'b1,1'b1,32'h200,1'b0,32'h04C,32'h048,1'b0,1'b0}, // R3 R7 stalled report
    '{1'b1,1'b0,1'b0,1'b0,32'h000,1'b0,32'h04C,32'h048,1'b0,1'b0}, // R7 report dropped
    '{1'b0,1'b0,1'b0,1'b0,32'h000,1'b0,32'h200,32'h04C,1'b1,1'b0}, // R7 applied
    '{1'b0,1'b1,1'b0,1'b0,32'h000,1'b0,32'h204,32'h200,1'b0,1'b1}, // R8 inject
    '{1'b0,1'b0,1'b0,1'b0,32'h000,1'b0,32'h208,32'h204,1'b0,1'b0}, // R2
    '{1'b1,1'b1,1'b0,1'b0,32'h000,1'b0,32'h208,32'h204,1'b0,1'b0}, // R8 inject while stalled
    '{1'b0,1'b0,1'b0,1'b0,32'h000,1'b0,32'h20C,32'h208,1'b0,1'b0}, // R2
    '{1'b0,1'b0,1'b1,1'b1,32'h300,1'b0,32'h300,32'h20C,1'b1,1'b0}, // R4
    '{1'b0,1'b0,1'b1,1'b1,32'h400,1'b1,32'h400,32'h300,1'b1,1'b0}, // R9 branch in slot
    '{1'b0,1'b0,1'b0,1'b0,32'h000,1'b0,32'h404,32'h400,1'b0,1'b0}  // R6
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        stallIn, injectNop, decBranch, decTaken;
  logic [31:0] decTarget, imemAddr, imemData, fetchInstr, fetchPc;
  logic        fetchValid, fetchSlot, branchInSlot;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0] ^ 16'hC3C3};
  endfunction

  assign imemData = memWord(imemAddr);

  fetch_sequencer i_fetch_sequencer (
    .clk(clk), .rstN(rstN), .stallIn(stallIn), .injectNop(injectNop),
    .decBranch(decBranch), .decTaken(decTaken), .decTarget(decTarget),
    .imemAddr(imemAddr), .imemData(imemData), .fetchValid(fetchValid),
    .fetchInstr(fetchInstr), .fetchPc(fetchPc), .fetchSlot(fetchSlot),
    .branchInSlot(branchInSlot)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic checkState(input logic [31:0] eAddr, input logic [31:0] ePc,
                            input logic eSlot, input logic eZero, input logic eValid);
    logic [31:0] eWord;
    eWord = eZero ? 32'h0 : memWord(ePc);
    chk(imemAddr == eAddr, "R2 R4 R5 R7 imemAddr", imemAddr, eAddr);
    chk(fetchPc == ePc, "R2 R3 fetchPc", fetchPc, ePc);
    chk(fetchSlot == eSlot, "R6 fetchSlot", 32'(fetchSlot), 32'(eSlot));
    chk(fetchInstr == eWord, "R2 R8 fetchInstr", fetchInstr, eWord);
    chk(fetchValid == eValid, "R2 fetchValid", 32'(fetchValid), 32'(eValid));
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    rstN = 1'b0; stallIn = 1'b0; injectNop = 1'b0;
    decBranch = 1'b0; decTaken = 1'b0; decTarget = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(imemAddr == 32'h0, "R1 imemAddr", imemAddr, 32'h0);
    chk(fetchValid == 1'b0, "R1 fetchValid", 32'(fetchValid), 32'h0);
    chk(fetchSlot == 1'b0, "R1 fetchSlot", 32'(fetchSlot), 32'h0);
    chk(fetchInstr == 32'h0, "R1 fetchInstr", fetchInstr, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      stallIn   = VECS[i].stall;
      injectNop = VECS[i].inj;
      decBranch = VECS[i].bv;
      decTaken  = VECS[i].bt;
      decTarget = VECS[i].tgt;
      #1;
      chk(branchInSlot == VECS[i].bis, "R9 branchInSlot", 32'(branchInSlot),
          32'(VECS[i].bis));
      @(posedge clk);
      #1;
      checkState(VECS[i].expAddr, VECS[i].expPc, VECS[i].expSlot, VECS[i].expZero, 1'b1);
      @(negedge clk);
    end

    // R1: reset in the middle of a run, with a redirect held during a stall
    stallIn = 1'b1; injectNop = 1'b0; decBranch = 1'b1; decTaken = 1'b1;
    decTarget = 32'h900;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkState(32'h0, 32'h0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    decBranch = 1'b0; decTaken = 1'b0; decTarget = '0;
    // R3: stalled right after reset, nothing becomes valid
    @(posedge clk);
    #1;
    checkState(32'h0, 32'h0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    // R1: the held redirect was dropped by reset, fetch restarts at zero
    stallIn = 1'b0;
    @(posedge clk);
    #1;
    checkState(32'h4, 32'h0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    @(posedge clk);
    #1;
    checkState(32'h8, 32'h4, 1'b0, 1'b0, 1'b1);

    summary();
  end

endmodule